// File: doc/BRIEF.md
# Cycle-Stealing Word Transfer Controller

This block moves single data words between one selected peripheral and main memory without any program-controlled data path. Software prepares a transfer by loading a start address and a word count, naming a device number, and then issuing either an inbound command (device to memory) or an outbound command (memory to device). From then on, each request from the selected device asks for one stolen memory cycle. The block grants that request only at the next machine-cycle boundary. In that single cycle it presents the address and, for inbound words, the data with a generated parity bit.

After every stolen cycle the address counter steps up by one and the remaining-word counter steps down by one. When the count reaches zero the block raises a done flag and stops accepting requests. Outbound words are checked against the stored parity bit, and a mismatch sets a sticky error flag. The block never raises an interrupt. The program only loses the stolen cycles.

Top module: `brk_xfer_ctl`

## Requirements
- R1: After reset brk_req, brk_act, mem_we, dev_rvalid, xfer_done and par_err are all 0.
- R2: A cmd_load while idle takes cmd_addr as the next memory address and cmd_count as the number of words. It also clears xfer_done and par_err.
- R3: While a transfer is armed, dev_req with dev_id equal to the last selected device (cmd_sel with cmd_dev) raises brk_req from the next cycle. A request from any other device number is ignored.
- R4: A pending request turns into exactly one stolen cycle. brk_act is high for the single cycle after the first clock edge at which cyc_strobe is seen with brk_req high, and brk_req falls at that same edge.
- R5: In an inbound stolen cycle (cmd_in), mem_we is 1 and mem_addr is the current address. mem_wdata[31:0] holds the word captured with the request, and mem_wdata[32] is the even parity bit (XOR of the 32 data bits). mem_we is 0 in every other cycle.
- R6: In an outbound stolen cycle (cmd_out), mem_we is 0 and mem_rdata is sampled. In the next cycle dev_rvalid pulses for one cycle and dev_rdata holds mem_rdata[31:0].
- R7: An outbound word whose mem_rdata[32] differs from the XOR of mem_rdata[31:0] sets par_err. par_err stays set until the next cmd_load.
- R8: After each stolen cycle the address rises by one and the count falls by one. When the count reaches zero, xfer_done is 1 from the next cycle, and further device requests are ignored.
- R9: A device request that arrives while one is pending or in its stolen cycle is dropped, so at most one word moves per boundary.
- R10: A direction command given with a loaded count of zero sets xfer_done in the next cycle, and no break is ever requested.
- R11: While a transfer is armed, cmd_load, cmd_sel, cmd_in and cmd_out have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_load | input | 1 | Load address and word counters |
| cmd_addr | input | 17 | Start address for cmd_load |
| cmd_count | input | 12 | Word count for cmd_load |
| cmd_sel | input | 1 | Select a device |
| cmd_dev | input | 6 | Device number for cmd_sel |
| cmd_in | input | 1 | Arm an inbound transfer (device to memory) |
| cmd_out | input | 1 | Arm an outbound transfer (memory to device) |
| dev_req | input | 1 | Device asks for one word transfer |
| dev_id | input | 6 | Number of the requesting device |
| dev_wdata | input | 32 | Inbound data word |
| cyc_strobe | input | 1 | Machine-cycle boundary |
| mem_rdata | input | 33 | Memory read word, parity in bit 32 |
| brk_req | output | 1 | Break requested from the sequencer |
| brk_act | output | 1 | Current cycle is stolen |
| mem_addr | output | 17 | Memory address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 33 | Memory write word, parity in bit 32 |
| dev_rdata | output | 32 | Outbound data word to the device |
| dev_rvalid | output | 1 | dev_rdata is valid |
| xfer_done | output | 1 | Word count exhausted |
| par_err | output | 1 | Outbound parity mismatch seen |

## Verification
A device request sampled at edge k shows as brk_req after k. A cyc_strobe sampled at edge m gives brk_act, mem_we and mem_addr for the cycle after m. Outbound data, parity error and xfer_done then appear after edge m+1. The bench drives inputs 1 ns after a rising edge and samples only on falling edges. Its scoreboard monitor compares a memory write when brk_act is seen high and a device word when dev_rvalid is seen high. It waits a fixed number of edges before checking brk_req, xfer_done and par_err.

// File: rtl/brk_pkg.sv
package brk_pkg;
   typedef enum logic {
      DIR_IN  = 1'b0,
      DIR_OUT = 1'b1
   } brk_dir_e;
endpackage

// File: rtl/brk_parity.sv
module brk_parity #(
   parameter int W   = 32,
   parameter bit ODD = 1'b0
) (
   input  logic [W-1:0] d,
   output logic         p
);
   generate
      if (ODD) begin : g_odd
         assign p = ~(^d);
      end else begin : g_even
         assign p = ^d;
      end
   endgenerate
endmodule

// File: rtl/brk_counters.sv
module brk_counters #(
   parameter int ADDR_W = 17,
   parameter int CNT_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [CNT_W-1:0]  ld_cnt,
   input  logic              step,
   output logic [ADDR_W-1:0] addr,
   output logic [CNT_W-1:0]  cnt,
   output logic              last,
   output logic              empty
);
   localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
   localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr <= '0;
         cnt  <= '0;
      end else if (load) begin
         addr <= ld_addr;
         cnt  <= ld_cnt;
      end else if (step) begin
         addr <= addr + ADDR_ONE;
         cnt  <= cnt - CNT_ONE;
      end
   end

   assign last  = (cnt == CNT_ONE);
   assign empty = (cnt == '0);
endmodule

// File: rtl/brk_xfer_ctl.sv
module brk_xfer_ctl #(
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 17,
   parameter int CNT_W      = 12,
   parameter int DEV_W      = 6,
   parameter bit ODD_PARITY = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_load,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [CNT_W-1:0]  cmd_count,
   input  logic              cmd_sel,
   input  logic [DEV_W-1:0]  cmd_dev,
   input  logic              cmd_in,
   input  logic              cmd_out,
   input  logic              dev_req,
   input  logic [DEV_W-1:0]  dev_id,
   input  logic [DATA_W-1:0] dev_wdata,
   input  logic              cyc_strobe,
   input  logic [DATA_W:0]   mem_rdata,
   output logic              brk_req,
   output logic              brk_act,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_we,
   output logic [DATA_W:0]   mem_wdata,
   output logic [DATA_W-1:0] dev_rdata,
   output logic              dev_rvalid,
   output logic              xfer_done,
   output logic              par_err
);
   import brk_pkg::*;

   localparam int WORD_W = DATA_W + 1;

   generate
      if (DATA_W < 1 || ADDR_W < 1 || CNT_W < 1 || DEV_W < 1) begin : g_bad_width
         $error("brk_xfer_ctl: every width parameter must be at least 1");
      end
   endgenerate

   logic              armed_q, pend_q, act_q, rvalid_q, done_q, err_q;
   brk_dir_e          dir_q;
   logic [DEV_W-1:0]  dev_q;
   logic [DATA_W-1:0] buf_q, rdata_q;
   logic [ADDR_W-1:0] addr;
   logic [CNT_W-1:0]  cnt;
   logic              last, empty;
   logic              wr_par, rd_par;
   logic              idle_load, idle_start, take_req;

   assign idle_load  = !armed_q && cmd_load;
   assign idle_start = !armed_q && !cmd_load && (cmd_in || cmd_out);
   assign take_req   = armed_q && !pend_q && !act_q && dev_req && (dev_id == dev_q);

   brk_counters #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (idle_load),
      .ld_addr (cmd_addr),
      .ld_cnt  (cmd_count),
      .step    (act_q),
      .addr    (addr),
      .cnt     (cnt),
      .last    (last),
      .empty   (empty)
   );

   brk_parity #(.W(DATA_W), .ODD(ODD_PARITY)) u_par_gen (
      .d (buf_q),
      .p (wr_par)
   );

   brk_parity #(.W(DATA_W), .ODD(ODD_PARITY)) u_par_chk (
      .d (mem_rdata[DATA_W-1:0]),
      .p (rd_par)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q  <= 1'b0;
         pend_q   <= 1'b0;
         act_q    <= 1'b0;
         rvalid_q <= 1'b0;
         done_q   <= 1'b0;
         err_q    <= 1'b0;
         dir_q    <= DIR_IN;
         dev_q    <= '0;
         buf_q    <= '0;
         rdata_q  <= '0;
      end else begin
         rvalid_q <= 1'b0;
         act_q    <= 1'b0;
         if (!armed_q && cmd_sel) begin
            dev_q <= cmd_dev;
         end
         if (idle_load) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
         end
         if (idle_start) begin
            dir_q <= cmd_out ? DIR_OUT : DIR_IN;
            if (empty) begin
               done_q <= 1'b1;
            end else begin
               armed_q <= 1'b1;
               done_q  <= 1'b0;
            end
         end
         if (take_req) begin
            pend_q <= 1'b1;
            buf_q  <= dev_wdata;
         end
         if (pend_q && cyc_strobe) begin
            pend_q <= 1'b0;
            act_q  <= 1'b1;
         end
         if (act_q) begin
            if (dir_q == DIR_OUT) begin
               rdata_q  <= mem_rdata[DATA_W-1:0];
               rvalid_q <= 1'b1;
               if (rd_par != mem_rdata[DATA_W]) begin
                  err_q <= 1'b1;
               end
            end
            if (last) begin
               done_q  <= 1'b1;
               armed_q <= 1'b0;
            end
         end
      end
   end

   assign brk_req    = pend_q;
   assign brk_act    = act_q;
   assign mem_addr   = addr;
   assign mem_we     = act_q && (dir_q == DIR_IN);
   assign mem_wdata  = WORD_W'({wr_par, buf_q});
   assign dev_rdata  = rdata_q;
   assign dev_rvalid = rvalid_q;
   assign xfer_done  = done_q;
   assign par_err    = err_q;
endmodule

// File: rtl/brk_xfer_chk.sv
module brk_xfer_chk #(
   parameter int DATA_W = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            brk_req,
   input logic            brk_act,
   input logic            cyc_strobe,
   input logic            mem_we,
   input logic [DATA_W:0] mem_wdata,
   input logic            dev_rvalid,
   input logic            xfer_done,
   input logic            par_err
);
   assert_stolen_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      brk_act |=> !brk_act);

   assert_stolen_granted_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(brk_act) |-> $past(brk_req && cyc_strobe));

   assert_write_in_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> brk_act);

   assert_write_parity_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_wdata[DATA_W] == ^mem_wdata[DATA_W-1:0]));

   assert_rvalid_after_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      dev_rvalid |-> ($past(brk_act) && !$past(mem_we)));

   assert_err_from_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(par_err) |-> ($past(brk_act) && !$past(mem_we)));

   assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |-> (!brk_req && !brk_act));
endmodule

bind brk_xfer_ctl brk_xfer_chk #(.DATA_W(DATA_W)) u_brk_xfer_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .brk_req    (brk_req),
   .brk_act    (brk_act),
   .cyc_strobe (cyc_strobe),
   .mem_we     (mem_we),
   .mem_wdata  (mem_wdata),
   .dev_rvalid (dev_rvalid),
   .xfer_done  (xfer_done),
   .par_err    (par_err)
);

// File: tb/brk_xfer_ctl_bench.sv
module brk_xfer_ctl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_load = 0, cmd_sel = 0, cmd_in = 0, cmd_out = 0;
   logic [16:0] cmd_addr = '0;
   logic [11:0] cmd_count = '0;
   logic [5:0]  cmd_dev = '0, dev_id = '0;
   logic        dev_req = 0, cyc_strobe = 0;
   logic [31:0] dev_wdata = '0;
   logic [32:0] mem_rdata;
   logic        brk_req, brk_act, mem_we, dev_rvalid, xfer_done, par_err;
   logic [16:0] mem_addr;
   logic [32:0] mem_wdata;
   logic [31:0] dev_rdata;

   int checks = 0, failures = 0, act_seen = 0;
   logic [49:0] exp_mem[$];
   logic [31:0] exp_dev[$];
   logic [16:0] bad_addr = '1;

   always #4 clk = ~clk;

   brk_xfer_ctl u_brk_xfer_ctl (.*);

   function automatic logic [31:0] pat(input logic [16:0] a);
      return {a[14:0], a} ^ 32'h5A3C_0F11;
   endfunction

   always_comb begin
      mem_rdata = {^pat(mem_addr), pat(mem_addr)};
      if (mem_addr == bad_addr) mem_rdata[32] = ~mem_rdata[32];
   end

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: scoreboard side
   always @(negedge clk) begin
      if (rst_n && brk_act) begin
         act_seen++;
         if (mem_we) begin
            if (exp_mem.size() == 0) chk(0, "R5 unexpected write", {15'd0, mem_addr, mem_wdata}, 0);
            else begin
               logic [49:0] e;
               e = exp_mem.pop_front();
               chk({mem_addr, mem_wdata} == e, "R5 write addr/data/parity", {15'd0, mem_addr, mem_wdata}, {14'd0, e});
            end
         end
      end
      if (rst_n && dev_rvalid) begin
         if (exp_dev.size() == 0) chk(0, "R6 unexpected read", dev_rdata, 0);
         else begin
            logic [31:0] e;
            e = exp_dev.pop_front();
            chk(dev_rdata == e, "R6 outbound word", dev_rdata, e);
         end
      end
   end

   task automatic tick(); @(posedge clk); #1; endtask

   task automatic load(input logic [16:0] a, input logic [11:0] n);
      cmd_load = 1; cmd_addr = a; cmd_count = n; tick(); cmd_load = 0;
   endtask

   task automatic sel(input logic [5:0] d);
      cmd_sel = 1; cmd_dev = d; tick(); cmd_sel = 0;
   endtask

   task automatic go(input bit outb);
      if (outb) cmd_out = 1; else cmd_in = 1;
      tick(); cmd_in = 0; cmd_out = 0;
   endtask

   // driver: one word; request, check brk_req, then a boundary strobe
   task automatic word(input logic [5:0] id, input logic [31:0] d, input logic [16:0] a,
                       input bit outb, input bit expect_req);
      dev_req = 1; dev_id = id; dev_wdata = d; tick(); dev_req = 0;
      @(negedge clk);
      chk(brk_req == expect_req, "R3 brk_req after device request", brk_req, expect_req);
      if (expect_req) begin
         if (outb) exp_dev.push_back(pat(a)); else exp_mem.push_back({a, ^d, d});
      end
      tick(); tick();
      cyc_strobe = 1; tick(); cyc_strobe = 0;
      @(negedge clk);
      chk(brk_req == 1'b0, "R4 brk_req falls at grant", brk_req, 0);
      tick(); tick();
   endtask

   initial begin
      fork
         begin
            repeat (20000) @(posedge clk);
            chk(0, "watchdog", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
         end
      join_none

      repeat (3) @(posedge clk); #1;
      @(negedge clk);
      chk({brk_req, brk_act, mem_we, dev_rvalid, xfer_done, par_err} == 6'b0, "R1 reset outputs",
          {brk_req, brk_act, mem_we, dev_rvalid, xfer_done, par_err}, 0);
      tick(); rst_n = 1; tick();

      // inbound transfer, 3 words from 0x100, device 5
      load(17'h00100, 12'd3); sel(6'd5); go(1'b0);
      // R11: commands while armed have no effect
      load(17'h1F000, 12'd9); sel(6'd7);
      word(6'd5, 32'h1234_5678, 17'h00100, 1'b0, 1'b1);
      word(6'd7, 32'hDEAD_BEEF, 17'h00101, 1'b0, 1'b0); // R3/R11: other id ignored
      word(6'd5, 32'h8000_0001, 17'h00101, 1'b0, 1'b1);
      chk(act_seen == 2, "R4 one stolen cycle per request", act_seen, 2);
      // R9: second request while pending is dropped
      dev_req = 1; dev_id = 6'd5; dev_wdata = 32'h0F0F_0F0F; tick();
      dev_wdata = 32'hFFFF_FFFF; tick(); dev_req = 0;
      exp_mem.push_back({17'h00102, ^32'h0F0F_0F0F, 32'h0F0F_0F0F});
      cyc_strobe = 1; tick(); cyc_strobe = 0; tick(); tick();
      @(negedge clk);
      chk(act_seen == 3, "R9 at most one word per boundary", act_seen, 3);
      chk(xfer_done == 1'b1, "R8 done when count reaches zero", xfer_done, 1);
      chk(exp_mem.size() == 0, "R5 all inbound writes seen", exp_mem.size(), 0);
      word(6'd5, 32'h5555_AAAA, 17'h0, 1'b0, 1'b0); // R8: ignored after done
      chk(act_seen == 3, "R8 no break after done", act_seen, 3);

      // outbound, 2 words from 0x0ABC, device 9, second word has bad parity
      load(17'h00ABC, 12'd2);
      @(negedge clk);
      chk(xfer_done == 1'b0, "R2 load clears done", xfer_done, 0);
      sel(6'd9); go(1'b1);
      word(6'd9, 32'h0, 17'h00ABC, 1'b1, 1'b1);
      @(negedge clk);
      chk(par_err == 1'b0, "R7 good parity no error", par_err, 0);
      bad_addr = 17'h00ABD;
      word(6'd9, 32'h0, 17'h00ABD, 1'b1, 1'b1);
      @(negedge clk);
      chk(par_err == 1'b1, "R7 parity mismatch flagged", par_err, 1);
      chk(xfer_done == 1'b1, "R8 outbound done", xfer_done, 1);
      chk(exp_dev.size() == 0, "R6 all outbound words seen", exp_dev.size(), 0);
      tick(); tick();
      @(negedge clk);
      chk(par_err == 1'b1, "R7 error sticky", par_err, 1);

      // R10 zero count
      bad_addr = '1;
      load(17'h00200, 12'd0);
      @(negedge clk);
      chk(par_err == 1'b0, "R2 load clears error", par_err, 0);
      go(1'b0);
      @(negedge clk);
      chk(xfer_done == 1'b1, "R10 zero count done at once", xfer_done, 1);
      word(6'd9, 32'h1, 17'h0, 1'b0, 1'b0);
      chk(act_seen == 5, "R10 no stolen cycle", act_seen, 5);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule